// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block watches the stream of bus write cycles that a host sends to a parallel NOR flash and works out which operating mode the device is in. It recognises the two-cycle unlock prefix, the command byte that follows it, and the short single-cycle commands that some modes accept. It then moves between array read, identification overlay, unlock bypass, program and erase (busy, suspended, failed) and write-buffer abort. An external program/erase engine is started, suspended and resumed through one-cycle strobes. That engine reports back on `eng_done` and `eng_fail`.

Write cycles arrive on a valid/ready interface. A write counts as accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops for exactly the one cycle in which a start, suspend or resume strobe is high. This gives the engine a cycle to latch the strobe. A write held valid during that cycle waits and is taken on the next edge. Reads are not on this interface. `status_sel` tells the read path whether to return status or array data.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (array read), `status_sel`, `fail_flag` and all strobes are 0, and `wr_ready` is 1.
- R2: The unlock prefix is data AAh at address 555h, then data 55h at address 2AAh. Only address bits [10:0] are compared, and upper address bits are ignored. A wrong data or address on either unlock cycle returns the decoder to idle, so a following command byte has no effect.
- R3: In array read, an unlocked command byte selects the next mode: 90h gives overlay (1), A0h gives program-data wait (8), 80h gives erase arm (9), 20h gives bypass (2), and 25h gives buffer count (10). Any other byte leaves mode 0.
- R4: In program-data wait, the next write raises `start_prog` for one cycle, enters program busy (5) and presents that write's address and data on `eng_addr`/`eng_data`. `eng_done` then returns to the mode the program was issued from (0, 2 or 4).
- R5: In erase arm, a second unlock followed by 30h raises `start_erase`, enters erase busy (3) and presents that cycle's address on `eng_addr`. Any other byte, or a broken unlock, returns to mode 0. `eng_done` in mode 3 returns to mode 0.
- R6: A single write of B0h suspends: from mode 3 to erase suspended (4), or from mode 5 to program suspended (6), each with a one-cycle `susp_req`. In any other mode it has no effect.
- R7: A single write of 30h resumes: from mode 4 to 3, or from mode 6 to 5, each with a one-cycle `resume_req`. In any other mode it is ignored.
- R8: In bypass (2), a single A0h goes to mode 8 and a single 25h goes to mode 10. Both return to 2 when the program completes. Only 90h followed directly by 00h returns to mode 0. F0h is ignored.
- R9: In mode 10 the next write gives a count N. If N is below BUF_WORDS, the block takes N+1 data writes (mode 11), then a confirm byte (mode 12). 29h starts a program (mode 5, `start_prog`). A count of BUF_WORDS or more, or any other confirm byte, enters write-buffer abort (7).
- R10: Abort (7) is left only by the full unlock followed by F0h, which goes to mode 0. A single F0h is ignored.
- R11: Overlay (1) is entered by unlock and 90h from mode 0 or mode 4. Only a single F0h leaves it, returning to the mode it was entered from.
- R12: `eng_fail` in mode 3 or 5 sets `fail_flag`. The flag holds, and `eng_done` and suspend are ignored, until a single F0h returns the block to mode 0 and clears the flag. `status_sel` is 1 in modes 3, 5 and 7 and 0 in the other modes.
- R13: `wr_ready` is 0 in the cycle a strobe is high. A write offered then is accepted on the following edge instead.
- R14: If `eng_done` and an accepted suspend write fall on the same edge, completion wins: the mode leaves busy, and no `susp_req` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write cycle offered |
| wr_ready | output | 1 | Write cycle can be taken this edge |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | DATA_W | Write cycle data; command byte in bits [7:0] |
| eng_done | input | 1 | Engine finished the running operation |
| eng_fail | input | 1 | Engine reports operation failure |
| mode | output | 4 | Current mode code |
| status_sel | output | 1 | 1 = reads return status, 0 = array/ID data |
| fail_flag | output | 1 | Failure indication (timeout bit) |
| start_erase | output | 1 | One-cycle sector erase start |
| start_prog | output | 1 | One-cycle program start |
| susp_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |
| eng_addr | output | ADDR_W | Address handed to the engine |
| eng_data | output | DATA_W | Data handed to the engine |

## Verification
The collision that matters is engine completion landing on the same edge as an accepted suspend write. The bench provokes it by raising `eng_done` and offering B0h in one cycle during an erase. It expects the mode to be back at array read with no suspend strobe. A second overlap is a write offered while a program start strobe holds `wr_ready` low. The bench changes the held data to a suspend byte and checks that the mode is still program busy one edge later, and program suspended the edge after that. Sweeps over every command byte after unlock, every single-cycle byte during erase, and buffer counts across the limit are compared with modes the bench computes itself.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    M_READ  = 4'd0,
    M_OVL   = 4'd1,
    M_BYP   = 4'd2,
    M_ERASE = 4'd3,
    M_ESUSP = 4'd4,
    M_PROG  = 4'd5,
    M_PSUSP = 4'd6,
    M_ABORT = 4'd7,
    M_PDATA = 4'd8,
    M_EARM  = 4'd9,
    M_BCNT  = 4'd10,
    M_BLOAD = 4'd11,
    M_BCONF = 4'd12
  } mode_e;

  localparam logic [7:0] C_UNL1    = 8'hAA;
  localparam logic [7:0] C_UNL2    = 8'h55;
  localparam logic [7:0] C_OVL     = 8'h90;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_BYP     = 8'h20;
  localparam logic [7:0] C_BUF     = 8'h25;
  localparam logic [7:0] C_CONFIRM = 8'h29;
  localparam logic [7:0] C_SECTOR  = 8'h30;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_RESET   = 8'hF0;
  localparam logic [7:0] C_ZERO    = 8'h00;

endpackage

// File: rtl/flash_unlock_det.sv
module flash_unlock_det #(
  parameter int CMD_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              acc,
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        data,
  output logic [1:0]        phase,
  output logic              cmd_cyc,
  output logic              broken
);
  import flash_seq_pkg::*;

  localparam logic [CMD_AW-1:0] A_FIRST  = CMD_AW'('h555);
  localparam logic [CMD_AW-1:0] A_SECOND = CMD_AW'('h2AA);

  logic hit1, hit2;
  assign hit1 = (addr_lo == A_FIRST)  && (data == C_UNL1);
  assign hit2 = (addr_lo == A_SECOND) && (data == C_UNL2);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase <= 2'd0;
    end else if (acc) begin
      case (phase)
        2'd0:    phase <= hit1 ? 2'd1 : 2'd0;
        2'd1:    phase <= hit2 ? 2'd2 : 2'd0;
        default: phase <= 2'd0;
      endcase
    end
  end

  assign cmd_cyc = en && acc && (phase == 2'd2);
  assign broken  = en && acc && (((phase == 2'd0) && !hit1) ||
                                 ((phase == 2'd1) && !hit2));
endmodule

// File: rtl/flash_wbuf_ctr.sv
module flash_wbuf_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= load_val;
    else if (dec)  left <= left - 1'b1;
  end

  assign zero = (left == '0);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int CMD_AW    = 11,
  parameter int BUF_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic [3:0]        mode,
  output logic              status_sel,
  output logic              fail_flag,
  output logic              start_erase,
  output logic              start_prog,
  output logic              susp_req,
  output logic              resume_req,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_data
);
  import flash_seq_pkg::*;

  localparam int CNT_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam logic [DATA_W-1:0] BUF_LIM = DATA_W'(BUF_WORDS);

  mode_e      st, ret;
  logic       byp_arm;
  logic       acc;
  logic [7:0] cb;
  logic [1:0] phase;
  logic       cmd_cyc, broken, unl_en;
  logic       cnt_zero, cnt_load, cnt_dec, too_big;
  logic       strobe_any;

  assign strobe_any = start_erase | start_prog | susp_req | resume_req;
  assign wr_ready   = !strobe_any;
  assign acc        = wr_valid && wr_ready;
  assign cb         = wr_data[7:0];
  assign unl_en     = (st == M_READ) || (st == M_ESUSP) ||
                      (st == M_EARM) || (st == M_ABORT);

  flash_unlock_det #(.CMD_AW(CMD_AW)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (unl_en),
    .acc     (acc),
    .addr_lo (wr_addr[CMD_AW-1:0]),
    .data    (cb),
    .phase   (phase),
    .cmd_cyc (cmd_cyc),
    .broken  (broken)
  );

  assign too_big  = (wr_data >= BUF_LIM);
  assign cnt_load = (st == M_BCNT) && acc && !too_big;
  assign cnt_dec  = (st == M_BLOAD) && acc && !cnt_zero;

  flash_wbuf_ctr #(.CNT_W(CNT_W)) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (wr_data[CNT_W-1:0]),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= M_READ;
      ret         <= M_READ;
      byp_arm     <= 1'b0;
      fail_flag   <= 1'b0;
      start_erase <= 1'b0;
      start_prog  <= 1'b0;
      susp_req    <= 1'b0;
      resume_req  <= 1'b0;
      eng_addr    <= '0;
      eng_data    <= '0;
    end else begin
      start_erase <= 1'b0;
      start_prog  <= 1'b0;
      susp_req    <= 1'b0;
      resume_req  <= 1'b0;
      if (st != M_BYP) byp_arm <= 1'b0;
      case (st)
        M_READ: begin
          if (cmd_cyc) begin
            case (cb)
              C_OVL:   begin st <= M_OVL;   ret <= M_READ; end
              C_PROG:  begin st <= M_PDATA; ret <= M_READ; end
              C_ERASE: st <= M_EARM;
              C_BYP:   st <= M_BYP;
              C_BUF:   begin st <= M_BCNT;  ret <= M_READ; eng_addr <= wr_addr; end
              default: ;
            endcase
          end
        end
        M_OVL: begin
          if (acc && cb == C_RESET) st <= ret;
        end
        M_BYP: begin
          if (acc) begin
            byp_arm <= (cb == C_OVL);
            if (byp_arm && cb == C_ZERO) st <= M_READ;
            else if (cb == C_PROG) begin st <= M_PDATA; ret <= M_BYP; end
            else if (cb == C_BUF) begin
              st <= M_BCNT; ret <= M_BYP; eng_addr <= wr_addr;
            end
          end
        end
        M_PDATA: begin
          if (acc) begin
            eng_addr   <= wr_addr;
            eng_data   <= wr_data;
            start_prog <= 1'b1;
            st         <= M_PROG;
          end
        end
        M_ERASE, M_PROG: begin
          if (fail_flag) begin
            if (acc && cb == C_RESET) begin
              st <= M_READ; fail_flag <= 1'b0;
            end
          end else if (eng_fail) begin
            fail_flag <= 1'b1;
          end else if (eng_done) begin
            st <= (st == M_ERASE) ? M_READ : ret;
          end else if (acc && cb == C_SUSP) begin
            st       <= (st == M_ERASE) ? M_ESUSP : M_PSUSP;
            susp_req <= 1'b1;
          end
        end
        M_ESUSP: begin
          if (cmd_cyc) begin
            case (cb)
              C_OVL:  begin st <= M_OVL;   ret <= M_ESUSP; end
              C_PROG: begin st <= M_PDATA; ret <= M_ESUSP; end
              C_BUF:  begin st <= M_BCNT;  ret <= M_ESUSP; eng_addr <= wr_addr; end
              default: ;
            endcase
          end else if (acc && phase == 2'd0 && cb == C_SECTOR) begin
            st <= M_ERASE; resume_req <= 1'b1;
          end
        end
        M_PSUSP: begin
          if (acc && cb == C_SECTOR) begin
            st <= M_PROG; resume_req <= 1'b1;
          end
        end
        M_EARM: begin
          if (cmd_cyc) begin
            if (cb == C_SECTOR) begin
              st <= M_ERASE; start_erase <= 1'b1; eng_addr <= wr_addr;
            end else begin
              st <= M_READ;
            end
          end else if (broken) begin
            st <= M_READ;
          end
        end
        M_BCNT: begin
          if (acc) st <= too_big ? M_ABORT : M_BLOAD;
        end
        M_BLOAD: begin
          if (acc && cnt_zero) st <= M_BCONF;
        end
        M_BCONF: begin
          if (acc) begin
            if (cb == C_CONFIRM) begin
              st <= M_PROG; start_prog <= 1'b1;
            end else begin
              st <= M_ABORT;
            end
          end
        end
        M_ABORT: begin
          if (cmd_cyc && cb == C_RESET) st <= M_READ;
        end
        default: st <= M_READ;
      endcase
    end
  end

  assign mode       = st;
  assign status_sel = (st == M_ERASE) || (st == M_PROG) || (st == M_ABORT);
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       fail_flag,
  input logic       eng_fail,
  input logic       start_erase,
  input logic       start_prog,
  input logic       susp_req,
  input logic       resume_req
);
  import flash_seq_pkg::*;

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_erase, start_prog, susp_req, resume_req}));

  // R5
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_erase |-> (mode == M_ERASE) && ($past(mode) == M_EARM));

  // R4
  prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> (mode == M_PROG));

  // R6
  susp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> ((mode == M_ESUSP) && ($past(mode) == M_ERASE)) ||
                 ((mode == M_PSUSP) && ($past(mode) == M_PROG)));

  // R7
  resume_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ((mode == M_ERASE) && ($past(mode) == M_ESUSP)) ||
                   ((mode == M_PROG) && ($past(mode) == M_PSUSP)));

  // R10
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == M_ABORT) && (mode != M_ABORT)) |-> (mode == M_READ));

  // R11
  ovl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == M_OVL) && (mode != M_OVL)) |->
      ((mode == M_READ) || (mode == M_ESUSP)));

  // R8
  byp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == M_BYP) && (mode != M_BYP)) |->
      ((mode == M_READ) || (mode == M_PDATA) || (mode == M_BCNT)));

  // R12
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(eng_fail));

  // R12
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> (mode == M_READ));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .fail_flag   (fail_flag),
  .eng_fail    (eng_fail),
  .start_erase (start_erase),
  .start_prog  (start_prog),
  .susp_req    (susp_req),
  .resume_req  (resume_req)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          eng_done = 1'b0;
  logic          eng_fail = 1'b0;
  logic [3:0]    mode;
  logic          status_sel, fail_flag, start_erase, start_prog, susp_req, resume_req;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] eng_data;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .CMD_AW(11), .BUF_WORDS(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_done(eng_done), .eng_fail(eng_fail),
    .mode(mode), .status_sel(status_sel), .fail_flag(fail_flag),
    .start_erase(start_erase), .start_prog(start_prog), .susp_req(susp_req),
    .resume_req(resume_req), .eng_addr(eng_addr), .eng_data(eng_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock(input logic [8:0] up);
    wr({up, 11'h555}, 16'h00AA);
    wr({up, 11'h2AA}, 16'h0055);
  endtask

  task automatic pulse(input bit is_fail);
    @(negedge clk);
    if (is_fail) eng_fail = 1'b1; else eng_done = 1'b1;
    @(negedge clk);
    eng_fail = 1'b0; eng_done = 1'b0;
  endtask

  function automatic int exp_cmd(input int c);
    case (c)
      'h90: return 1;
      'hA0: return 8;
      'h80: return 9;
      'h20: return 2;
      'h25: return 10;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 status_sel", status_sel, 0);
    chk("R1 fail_flag", fail_flag, 0);
    chk("R1 strobes", {start_erase, start_prog, susp_req, resume_req}, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // R3 sweep of every command byte; R2 upper address bits vary
    for (int c = 0; c < 256; c++) begin
      int e;
      e = exp_cmd(c);
      unlock(9'(c));
      wr({9'(c * 3), 11'h555}, 16'(c));
      chk("R3 command byte mode", mode, e);
      case (e)
        1: wr('0, 16'h00F0);
        8: begin wr(20'h00100, 16'h1234); pulse(1'b0); end
        2: begin wr('0, 16'h0090); wr('0, 16'h0000); end
        9: wr('0, 16'h0000);
        10: begin wr('0, 16'h0000); wr('0, 16'h4321); wr('0, 16'h0029); pulse(1'b0); end
        default: ;
      endcase
      chk("R3 back to read", mode, 0);
    end

    // R2 broken unlock cycles
    wr(20'h00555, 16'h00AB); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h0090);
    chk("R2 bad first data", mode, 0);
    wr(20'h00555, 16'h00AA); wr(20'h002AB, 16'h0055); wr(20'h00555, 16'h0090);
    chk("R2 bad second address", mode, 0);
    wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0054); wr(20'h00555, 16'h0090);
    chk("R2 bad second data", mode, 0);

    // R6 / R7 ignored in read
    wr('0, 16'h00B0); chk("R6 suspend in read ignored", mode, 0);
    wr('0, 16'h0030); chk("R7 resume in read ignored", mode, 0);

    // R5 erase start
    unlock(0); wr(20'h00555, 16'h0080); unlock(0);
    wr(20'h12345, 16'h0030);
    chk("R5 start_erase", start_erase, 1);
    chk("R5 erase mode", mode, 3);
    chk("R5 eng_addr", eng_addr, 'h12345);
    chk("R12 status in erase", status_sel, 1);
    // R6 / R7 sweep of single bytes during erase
    for (int d = 0; d < 256; d++) begin
      wr('0, 16'(d));
      if (d == 'hB0) begin
        chk("R6 suspend strobe", susp_req, 1);
        chk("R6 erase suspended", mode, 4);
        chk("R12 status in suspend", status_sel, 0);
        wr('0, 16'h0030);
        chk("R7 resume strobe", resume_req, 1);
        chk("R7 erase resumed", mode, 3);
      end else begin
        chk("R6 other byte in erase", mode, 3);
      end
    end
    pulse(1'b0);
    chk("R5 erase done", mode, 0);

    // R11 overlay from erase suspend
    unlock(0); wr(20'h00555, 16'h0080); unlock(0); wr(20'h00000, 16'h0030);
    wr('0, 16'h00B0);
    unlock(0); wr(20'h00555, 16'h0090);
    chk("R11 overlay entered", mode, 1);
    wr('0, 16'h0030);
    chk("R11 non-exit ignored", mode, 1);
    wr('0, 16'h00F0);
    chk("R11 exit to suspend", mode, 4);
    // R4 program during erase suspend
    unlock(0); wr(20'h00555, 16'h00A0); wr(20'h00222, 16'h0777);
    chk("R4 prog from suspend", mode, 5);
    pulse(1'b0);
    chk("R4 return to suspend", mode, 4);
    wr('0, 16'h0030); pulse(1'b0);
    chk("R5 erase done again", mode, 0);

    // R4 / R13 program with write held during strobe
    unlock(0); wr(20'h00555, 16'h00A0);
    chk("R4 program data wait", mode, 8);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 20'h0ABCD; wr_data = 16'h005A;
    @(negedge clk);
    chk("R4 start_prog", start_prog, 1);
    chk("R4 eng_addr", eng_addr, 'h0ABCD);
    chk("R4 eng_data", eng_data, 'h5A);
    chk("R13 ready low", wr_ready, 0);
    wr_data = 16'h00B0;
    @(negedge clk);
    chk("R13 held write not taken", mode, 5);
    chk("R13 ready back", wr_ready, 1);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R6 program suspended", mode, 6);
    chk("R6 susp strobe", susp_req, 1);
    wr('0, 16'h0030);
    chk("R7 program resumed", mode, 5);
    pulse(1'b0);
    chk("R4 program done", mode, 0);

    // R8 bypass
    unlock(0); wr(20'h00555, 16'h0020);
    chk("R8 bypass entered", mode, 2);
    wr('0, 16'h00F0); chk("R8 F0 ignored", mode, 2);
    wr('0, 16'h00A0); wr(20'h00010, 16'h0011);
    chk("R8 bypass program", mode, 5);
    pulse(1'b0); chk("R8 return to bypass", mode, 2);
    wr('0, 16'h0090); wr('0, 16'h0055); wr('0, 16'h0000);
    chk("R8 broken bypass reset", mode, 2);
    wr('0, 16'h0025); wr('0, 16'h0000); wr('0, 16'h0001); wr('0, 16'h0029);
    chk("R8 bypass buffer program", mode, 5);
    pulse(1'b0); chk("R8 buffer back to bypass", mode, 2);
    wr('0, 16'h0090); wr('0, 16'h0000);
    chk("R8 bypass reset", mode, 0);

    // R9 / R10 buffer count sweep across the limit
    for (int n = 0; n < BW + 4; n++) begin
      unlock(0); wr(20'h04555, 16'h0025);
      wr('0, 16'(n));
      if (n < BW) begin
        for (int k = 0; k <= n; k++) begin
          chk("R9 loading", mode, 11);
          wr('0, 16'(k + 7));
        end
        chk("R9 confirm wait", mode, 12);
        wr('0, 16'h0029);
        chk("R9 start_prog", start_prog, 1);
        chk("R9 program", mode, 5);
        pulse(1'b0);
        chk("R9 done", mode, 0);
      end else begin
        chk("R9 count too big aborts", mode, 7);
        chk("R12 status in abort", status_sel, 1);
        wr('0, 16'h00F0);
        chk("R10 single reset ignored", mode, 7);
        unlock(0); wr(20'h00555, 16'h00F0);
        chk("R10 full reset", mode, 0);
      end
    end
    unlock(0); wr(20'h00555, 16'h0025); wr('0, 16'h0000); wr('0, 16'h0001);
    wr('0, 16'h0030);
    chk("R9 bad confirm aborts", mode, 7);
    unlock(0); wr(20'h00555, 16'h00F0);
    chk("R10 full reset after confirm", mode, 0);

    // R12 failure handling
    unlock(0); wr(20'h00555, 16'h0080); unlock(0); wr(20'h00000, 16'h0030);
    pulse(1'b1);
    chk("R12 fail_flag set", fail_flag, 1);
    chk("R12 mode held", mode, 3);
    pulse(1'b0);
    chk("R12 done ignored", mode, 3);
    wr('0, 16'h00B0);
    chk("R12 suspend ignored", mode, 3);
    chk("R12 flag held", fail_flag, 1);
    wr('0, 16'h00F0);
    chk("R12 reset to read", mode, 0);
    chk("R12 flag cleared", fail_flag, 0);

    // R14 done and suspend on the same edge
    unlock(0); wr(20'h00555, 16'h0080); unlock(0); wr(20'h00000, 16'h0030);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = '0; wr_data = 16'h00B0; eng_done = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; eng_done = 1'b0;
    chk("R14 done wins mode", mode, 0);
    chk("R14 no suspend strobe", susp_req, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule